// File: doc/BRIEF.md
# Receive Frame Descriptor Writer

This block is the receive engine of a network controller. It places each incoming frame into a receive descriptor that lives in host memory. Every descriptor uses the simple layout, where the frame payload sits inside the descriptor itself. The block reaches host memory through a 32-bit word master that uses a request/acknowledge handshake. Frames arrive as a byte stream, with markers for the first and last byte. The host controls the block with a small set of command codes and a general pointer operand.

When a frame starts and the receive state is ready, the engine first reads three words of the current descriptor: control, link and size. It then accepts bytes and packs them into words, which it writes at descriptor offset 0x10. After the last data word it writes back the control word with the complete and OK flags set. It then writes the size word with the end-of-frame flag and the byte count. Two flags in the control word decide what happens next. The engine either stops in the no-resources state, stops in the suspended state, or moves on to the descriptor named by the link field. Frames that arrive in any other state are consumed and thrown away.

The controller walks through these named states: `F_WAIT`, `F_DROP`, `F_RD_CTRL`, `F_RD_LINK`, `F_RD_SIZE`, `F_COLLECT`, `F_WR_DATA`, `F_WR_CTRL`, `F_WR_SIZE`, `F_FINISH`, `F_RS_CTRL` and `F_RS_LINK`. The transitions are:
- `F_WAIT` goes to `F_RD_CTRL` on a frame start while ready, to `F_DROP` on a frame start otherwise, and to `F_RS_CTRL` on a resume while ready.
- The three reads go `F_RD_CTRL`, then `F_RD_LINK`, then `F_RD_SIZE`, then `F_COLLECT`.
- `F_COLLECT` goes to `F_WR_DATA` when a word is full or the last byte arrives. `F_WR_DATA` goes back to `F_COLLECT`, or on to `F_WR_CTRL` once the last byte has been taken.
- `F_WR_CTRL` goes to `F_WR_SIZE`, then to `F_FINISH`, then back to `F_WAIT`.
- `F_RS_CTRL` goes to `F_RS_LINK` when the suspend flag is clear, and back to `F_WAIT` otherwise. `F_RS_LINK` goes to `F_WAIT`.
- `F_DROP` goes to `F_WAIT` on the last byte.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset the receive state is idle (code 0), the good-frame count is 0, no event is raised and no memory request is made.
- R2: Command code 1 sets the descriptor offset to the general pointer and the state to ready (code 4). Code 6 sets the base to the general pointer. Codes 0, 3, 4, 5 and 7 change nothing. The state codes are idle 0, suspended 1, no-resources 2 and ready 4.
- R3: A frame that starts while the state is not ready is consumed without any memory access, without events and without a change in count.
- R4: Frame bytes are written little-endian into 32-bit words at base + offset + 0x10 and upward. Byte 0 goes in bits 7:0. A trailing partial word is zero-filled, and no word is written past the frame.
- R5: After the data words, the control word (descriptor word 0, at +0x0) is written back with bit 15 and bit 13 set and its other bits unchanged. This happens before the size word is written.
- R6: The size word (descriptor word 3, at +0xC) is written last. Its upper 16 bits are kept, and its low 16 bits become 0x8000 plus the frame length plus 4.
- R7: Each stored frame gives a one-cycle frame-received pulse and increments the good-frame count by one.
- R8: If control bit 31 is set, the state becomes no-resources (2) and a receive-not-ready pulse is given, even when bit 30 is also set.
- R9: If bit 31 is clear and bit 30 is set, the state becomes suspended (1) and a receive-not-ready pulse is given.
- R10: If both bits are clear, the state stays ready and the offset becomes the link value (descriptor word 1, at +0x4). The next frame is therefore stored at base + link.
- R11: Resume (code 2) acts only when the state is ready. It reads the current control word and, only if bit 30 is clear, reads the link word and moves the offset to it. In any other state it makes no memory access.
- R12: A memory request keeps its address, direction and write data stable until it is acknowledged. The read-read-read-write-write pattern per frame uses three reads, one write per data word and two descriptor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Command taken this cycle when high with cmd_valid |
| cmd_code | input | 3 | Receive command code |
| gen_ptr | input | ADDR_W | General pointer operand |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Frame byte accepted |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| ev_frame | output | 1 | Frame-received pulse |
| ev_not_ready | output | 1 | Receive-not-ready pulse |
| good_count | output | CNT_W | Stored frame count |
| ru_state | output | 3 | Receive state code |

## Verification
The bench checks data packing with frame lengths of 1, 3, 4, 6 and 8 bytes. A design that forgets the zero fill would leave stale bytes in the last word. An off-by-one in the word count would write an extra word past the frame or drop the last one. The size word is tested with a non-zero upper half, so a design that overwrites the upper half, or leaves out the four CRC bytes, shows a wrong value. A descriptor with both end-of-list and suspend set catches a design that gives suspend priority. A resume is issued while suspended, and the bench expects no memory access; a design that acts there would show reads. A resume is also issued on a descriptor that still has its suspend flag set; a design that ignores the flag would store the next frame at the linked descriptor instead of the current one.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        RU_IDLE  = 3'd0,
        RU_SUSP  = 3'd1,
        RU_NORES = 3'd2,
        RU_READY = 3'd4
    } ru_state_e;

    typedef enum logic [3:0] {
        F_WAIT,
        F_DROP,
        F_RD_CTRL,
        F_RD_LINK,
        F_RD_SIZE,
        F_COLLECT,
        F_WR_DATA,
        F_WR_CTRL,
        F_WR_SIZE,
        F_FINISH,
        F_RS_CTRL,
        F_RS_LINK
    } fsm_e;

    localparam logic [2:0] RUC_START  = 3'd1;
    localparam logic [2:0] RUC_RESUME = 3'd2;
    localparam logic [2:0] RUC_LDBASE = 3'd6;

    localparam int CB_END_LIST = 31;
    localparam int CB_SUSPEND  = 30;
    localparam int CB_DONE     = 15;
    localparam int CB_GOOD     = 13;

    localparam int        OFS_LINK  = 4;
    localparam int        OFS_SIZE  = 12;
    localparam int        OFS_DATA  = 16;
    localparam logic [15:0] SIZE_EOF  = 16'h8000;
    localparam int        CRC_BYTES = 4;

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
    parameter int W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [7:0]                    byte_in,
    output logic [W-1:0]                  word_out,
    output logic [$clog2(W/8):0]          fill
);
    localparam int LANES = W / 8;
    localparam int LW    = $clog2(LANES);

    logic [W-1:0] word_q;
    logic [LW:0]  fill_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word_q <= '0;
            fill_q <= '0;
        end else if (push) begin
            word_q[fill_q[LW-1:0]*8 +: 8] <= byte_in;
            fill_q <= fill_q + 1'b1;
        end
    end

    assign word_out = word_q;
    assign fill     = fill_q;

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= (LW+1)'(LANES));

endmodule

// File: rtl/rxd_tally.sv
module rxd_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (done) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(cnt_q));

endmodule

// File: rtl/rxd_ctx.sv
module rxd_ctx
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_start,
    input  logic              do_base,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              do_adv,
    input  logic [ADDR_W-1:0] link,
    input  logic              do_nores,
    input  logic              do_susp,
    output ru_state_e         state,
    output logic [ADDR_W-1:0] desc_addr
);
    ru_state_e         st_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RU_IDLE;
            base_q <= '0;
            ofs_q  <= '0;
        end else begin
            if (do_base) base_q <= ptr;
            if (do_start) begin
                ofs_q <= ptr;
                st_q  <= RU_READY;
            end else if (do_nores) begin
                st_q  <= RU_NORES;
            end else if (do_susp) begin
                st_q  <= RU_SUSP;
            end else if (do_adv) begin
                ofs_q <= link;
            end
        end
    end

    assign state     = st_q;
    assign desc_addr = base_q + ofs_q;

    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q inside {RU_IDLE, RU_SUSP, RU_NORES, RU_READY});

    p_start_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_start |=> st_q == RU_READY);

    p_nores_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_nores && !do_start) |=> st_q == RU_NORES);

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] gen_ptr,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              ev_frame,
    output logic              ev_not_ready,
    output logic [CNT_W-1:0]  good_count,
    output logic [2:0]        ru_state
);
    localparam int WB    = 32;
    localparam int LANES = WB / 8;
    localparam int FW    = $clog2(LANES) + 1;

    fsm_e fsm_q, fsm_nx;

    logic [31:0]       ctrl_q;
    logic [31:0]       link_q;
    logic [15:0]       size_hi_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] wptr_q;
    logic              eof_q;

    ru_state_e         st;
    logic [ADDR_W-1:0] desc_addr;
    logic [31:0]       pk_word;
    logic [FW-1:0]     pk_fill;
    logic              pk_clr, pk_push;

    logic cmd_take, c_start, c_base, c_resume;
    logic byte_take, last_lane;
    logic adv, go_nores, go_susp, done;
    logic [ADDR_W-1:0] adv_link;
    logic [15:0]       size_lo;

    assign cmd_take  = (fsm_q == F_WAIT) && cmd_valid;
    assign c_start   = cmd_take && (cmd_code == RUC_START);
    assign c_base    = cmd_take && (cmd_code == RUC_LDBASE);
    assign c_resume  = cmd_take && (cmd_code == RUC_RESUME) && (st == RU_READY);
    assign byte_take = rx_valid && rx_ready;
    assign last_lane = (pk_fill == FW'(LANES - 1));
    assign size_lo   = SIZE_EOF | (16'(len_q) + 16'(CRC_BYTES));

    rxd_ctx #(.ADDR_W(ADDR_W)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_start  (c_start),
        .do_base   (c_base),
        .ptr       (gen_ptr),
        .do_adv    (adv),
        .link      (adv_link),
        .do_nores  (go_nores),
        .do_susp   (go_susp),
        .state     (st),
        .desc_addr (desc_addr)
    );

    rxd_packer #(.W(WB)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pk_clr),
        .push     (pk_push),
        .byte_in  (rx_data),
        .word_out (pk_word),
        .fill     (pk_fill)
    );

    rxd_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .count (good_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= F_WAIT;
        else        fsm_q <= fsm_nx;
    end

    // next-state logic
    always_comb begin
        fsm_nx = fsm_q;
        unique case (fsm_q)
            F_WAIT: begin
                if (cmd_valid) begin
                    if (c_resume) fsm_nx = F_RS_CTRL;
                end else if (rx_valid && rx_sof) begin
                    fsm_nx = (st == RU_READY) ? F_RD_CTRL : F_DROP;
                end
            end
            F_DROP:    if (rx_valid && rx_eof) fsm_nx = F_WAIT;
            F_RD_CTRL: if (mem_ack) fsm_nx = F_RD_LINK;
            F_RD_LINK: if (mem_ack) fsm_nx = F_RD_SIZE;
            F_RD_SIZE: if (mem_ack) fsm_nx = F_COLLECT;
            F_COLLECT: if (byte_take && (rx_eof || last_lane)) fsm_nx = F_WR_DATA;
            F_WR_DATA: if (mem_ack) fsm_nx = eof_q ? F_WR_CTRL : F_COLLECT;
            F_WR_CTRL: if (mem_ack) fsm_nx = F_WR_SIZE;
            F_WR_SIZE: if (mem_ack) fsm_nx = F_FINISH;
            F_FINISH:  fsm_nx = F_WAIT;
            F_RS_CTRL: if (mem_ack) fsm_nx = mem_rdata[CB_SUSPEND] ? F_WAIT : F_RS_LINK;
            F_RS_LINK: if (mem_ack) fsm_nx = F_WAIT;
            default:   fsm_nx = F_WAIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            link_q    <= '0;
            size_hi_q <= '0;
            len_q     <= '0;
            wptr_q    <= '0;
            eof_q     <= 1'b0;
        end else begin
            unique case (fsm_q)
                F_WAIT: begin
                    len_q  <= '0;
                    wptr_q <= '0;
                    eof_q  <= 1'b0;
                end
                F_RD_CTRL: if (mem_ack) ctrl_q    <= mem_rdata;
                F_RD_LINK: if (mem_ack) link_q    <= mem_rdata;
                F_RD_SIZE: if (mem_ack) size_hi_q <= mem_rdata[31:16];
                F_COLLECT: if (byte_take) begin
                    len_q <= len_q + 1'b1;
                    if (rx_eof) eof_q <= 1'b1;
                end
                F_WR_DATA: if (mem_ack) wptr_q <= wptr_q + ADDR_W'(LANES);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        cmd_ready = 1'b0;
        pk_clr    = 1'b0;
        pk_push   = 1'b0;
        done      = 1'b0;
        adv       = 1'b0;
        adv_link  = link_q;
        go_nores  = 1'b0;
        go_susp   = 1'b0;
        unique case (fsm_q)
            F_WAIT: begin
                cmd_ready = 1'b1;
                rx_ready  = rx_valid && !rx_sof && !cmd_valid;
                pk_clr    = 1'b1;
            end
            F_DROP:    rx_ready = 1'b1;
            F_RD_CTRL: mem_req  = 1'b1;
            F_RD_LINK: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFS_LINK);
            end
            F_RD_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFS_SIZE);
            end
            F_COLLECT: begin
                rx_ready = 1'b1;
                pk_push  = rx_valid;
            end
            F_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFS_DATA) + wptr_q;
                mem_wdata = pk_word;
                pk_clr    = mem_ack;
            end
            F_WR_CTRL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ctrl_q | (32'd1 << CB_DONE) | (32'd1 << CB_GOOD);
            end
            F_WR_SIZE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFS_SIZE);
                mem_wdata = {size_hi_q, size_lo};
            end
            F_FINISH: begin
                done     = 1'b1;
                go_nores = ctrl_q[CB_END_LIST];
                go_susp  = !ctrl_q[CB_END_LIST] && ctrl_q[CB_SUSPEND];
                adv      = !ctrl_q[CB_END_LIST] && !ctrl_q[CB_SUSPEND];
            end
            F_RS_CTRL: mem_req = 1'b1;
            F_RS_LINK: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFS_LINK);
                adv      = mem_ack;
                adv_link = mem_rdata;
            end
            default: ;
        endcase
    end

    assign ev_frame     = done;
    assign ev_not_ready = go_nores || go_susp;
    assign ru_state     = st;

    p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    p_store_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> st == RU_READY);

    p_rnr_with_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_not_ready |-> ev_frame);

    p_frame_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |=> !ev_frame);

    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00 || desc_addr[1:0] != 2'b00);

endmodule

// File: tb/rx_desc_writer_test.sv
module rx_desc_writer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_code = '0;
    logic [31:0] gen_ptr = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ev_frame, ev_not_ready;
    logic [31:0] good_count;
    logic [2:0]  ru_state;

    always #5 clk = ~clk;

    rx_desc_writer uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code), .gen_ptr(gen_ptr),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ev_frame(ev_frame), .ev_not_ready(ev_not_ready),
        .good_count(good_count), .ru_state(ru_state)
    );

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [0:255];
    int          lat = 0;
    int          lat_cnt = 0;
    int          op_cnt = 0;
    logic [31:0] last_wr = '0;
    logic [31:0] prev_wr = '0;
    int          n_fr = 0;
    int          n_rnr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat_cnt >= lat) begin
                    mem_ack <= 1'b1;
                    lat_cnt <= 0;
                    op_cnt  <= op_cnt + 1;
                    if (mem_we) begin
                        mem[mem_addr[9:2]] <= mem_wdata;
                        prev_wr <= last_wr;
                        last_wr <= mem_addr;
                    end else begin
                        mem_rdata <= mem[mem_addr[9:2]];
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (ev_frame)     n_fr  = n_fr + 1;
        if (ev_not_ready) n_rnr = n_rnr + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] v);
        mem[a[9:2]] = v;
    endtask

    function automatic logic [31:0] get(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] c, input logic [31:0] p);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        gen_ptr   = p;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_data  = seed + 8'(i);
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1", "state", 32'(ru_state), 32'd0);
        chk("R1", "count", good_count, 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "events", 32'(ev_frame | ev_not_ready), 32'd0);
    endtask

    task automatic t_drop_idle();
        int ops0 = op_cnt, fr0 = n_fr;
        send_frame(5, 8'h70);
        chk("R3", "mem ops while idle", 32'(op_cnt - ops0), 32'd0);
        chk("R3", "events while idle", 32'(n_fr - fr0), 32'd0);
        chk("R3", "count while idle", good_count, 32'd0);
    endtask

    task automatic t_first_frame();
        int ops0, fr0, rnr0;
        put(32'h0A0, 32'h0000_0000); put(32'h0A4, 32'h60);
        put(32'h0AC, 32'hABCD_0000);
        put(32'h0B0, '1); put(32'h0B4, '1); put(32'h0B8, '1);
        lat = 0;
        send_cmd(3'd6, 32'h80);
        send_cmd(3'd1, 32'h20);
        chk("R2", "state after start", 32'(ru_state), 32'd4);
        ops0 = op_cnt; fr0 = n_fr; rnr0 = n_rnr;
        send_frame(6, 8'h11);
        chk("R4", "word0", get(32'h0B0), 32'h1413_1211);
        chk("R4", "word1 zero fill", get(32'h0B4), 32'h0000_1615);
        chk("R4", "no extra word", get(32'h0B8), 32'hFFFF_FFFF);
        chk("R5", "ctrl writeback", get(32'h0A0), 32'h0000_A000);
        chk("R6", "size word", get(32'h0AC), 32'hABCD_800A);
        chk("R5", "ctrl before size", prev_wr, 32'h0A0);
        chk("R6", "size last", last_wr, 32'h0AC);
        chk("R12", "op count", 32'(op_cnt - ops0), 32'd7);
        chk("R7", "frame pulse", 32'(n_fr - fr0), 32'd1);
        chk("R7", "count", good_count, 32'd1);
        chk("R10", "no rnr", 32'(n_rnr - rnr0), 32'd0);
        chk("R10", "still ready", 32'(ru_state), 32'd4);
    endtask

    task automatic t_link_suspend();
        int rnr0;
        put(32'h0E0, 32'h4000_0000); put(32'h0E4, 32'h0);
        put(32'h0EC, 32'h1234_0000); put(32'h0F8, 32'hDEAD_BEEF);
        lat = 2;
        rnr0 = n_rnr;
        send_frame(8, 8'h21);
        chk("R10", "linked word0", get(32'h0F0), 32'h2423_2221);
        chk("R4", "linked word1", get(32'h0F4), 32'h2827_2625);
        chk("R4", "exact words", get(32'h0F8), 32'hDEAD_BEEF);
        chk("R5", "ctrl keeps S", get(32'h0E0), 32'h4000_A000);
        chk("R6", "size len8", get(32'h0EC), 32'h1234_800C);
        chk("R9", "suspended", 32'(ru_state), 32'd1);
        chk("R9", "rnr pulse", 32'(n_rnr - rnr0), 32'd1);
        chk("R7", "count", good_count, 32'd2);
    endtask

    task automatic t_suspended_ignores();
        int ops0 = op_cnt, fr0 = n_fr;
        send_frame(3, 8'h90);
        chk("R3", "no ops suspended", 32'(op_cnt - ops0), 32'd0);
        chk("R3", "no frame event", 32'(n_fr - fr0), 32'd0);
        send_cmd(3'd2, 32'h0);
        chk("R11", "resume ignored ops", 32'(op_cnt - ops0), 32'd0);
        chk("R11", "resume keeps state", 32'(ru_state), 32'd1);
    endtask

    task automatic t_end_list();
        int rnr0;
        put(32'h180, 32'hC000_0000); put(32'h184, 32'h0); put(32'h18C, 32'h0);
        put(32'h190, '1);
        lat = 1;
        send_cmd(3'd1, 32'h100);
        rnr0 = n_rnr;
        send_frame(1, 8'h5A);
        chk("R4", "single byte", get(32'h190), 32'h0000_005A);
        chk("R5", "ctrl EL+S", get(32'h180), 32'hC000_A000);
        chk("R6", "size len1", get(32'h18C), 32'h0000_8005);
        chk("R8", "no resources", 32'(ru_state), 32'd2);
        chk("R8", "rnr pulse", 32'(n_rnr - rnr0), 32'd1);
    endtask

    task automatic t_ignored_codes();
        int ops0 = op_cnt;
        send_cmd(3'd0, 32'h300);
        send_cmd(3'd3, 32'h300);
        send_cmd(3'd4, 32'h300);
        send_cmd(3'd5, 32'h300);
        send_cmd(3'd7, 32'h300);
        chk("R2", "ignored codes state", 32'(ru_state), 32'd2);
        chk("R2", "ignored codes ops", 32'(op_cnt - ops0), 32'd0);
    endtask

    task automatic t_resume_advance();
        int ops0;
        put(32'h1C0, 32'h0); put(32'h1C4, 32'h1C0); put(32'h1D0, '1);
        put(32'h240, 32'h8000_0000); put(32'h244, 32'h0); put(32'h24C, 32'h0);
        lat = 3;
        send_cmd(3'd1, 32'h140);
        ops0 = op_cnt;
        send_cmd(3'd2, 32'h0);
        chk("R11", "resume reads", 32'(op_cnt - ops0), 32'd2);
        send_frame(4, 8'h31);
        chk("R11", "frame at linked desc", get(32'h250), 32'h3433_3231);
        chk("R11", "old desc untouched", get(32'h1D0), 32'hFFFF_FFFF);
        chk("R8", "end of list", 32'(ru_state), 32'd2);
    endtask

    task automatic t_resume_blocked();
        int ops0;
        put(32'h280, 32'h4000_0000); put(32'h284, 32'h40); put(32'h28C, 32'h0);
        put(32'h290, '1);
        lat = 1;
        send_cmd(3'd1, 32'h200);
        ops0 = op_cnt;
        send_cmd(3'd2, 32'h0);
        chk("R11", "blocked resume one read", 32'(op_cnt - ops0), 32'd1);
        chk("R11", "still ready", 32'(ru_state), 32'd4);
        send_frame(3, 8'h41);
        chk("R11", "frame at same desc", get(32'h290), 32'h0043_4241);
        chk("R5", "ctrl", get(32'h280), 32'h4000_A000);
        chk("R9", "suspended", 32'(ru_state), 32'd1);
        chk("R7", "final count", good_count, 32'd5);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_drop_idle();
        t_first_frame();
        t_link_suspend();
        t_suspended_ignores();
        t_end_list();
        t_ignored_codes();
        t_resume_advance();
        t_resume_blocked();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule